// File: doc/BRIEF.md
# Serial Control-Register Target with Auto-Increment

This block is a write-only two-wire serial bus target. A host microcontroller uses it to load a small bank of 8-bit control registers. Each register steers one analog function: source select with input gain and mute, automatic gain control, surround, volume, tone, and the left and right balance attenuators. The block samples both bus lines with the system clock and synchronises them. It detects start and stop conditions, shifts in bytes MSB first, and acknowledges every byte it accepts by pulling the data line low through an output enable.

A transfer consists of a device address byte, a subaddress byte and one or more data bytes. The subaddress carries an increment flag. When the flag is clear, every data byte overwrites the one register that was named. When the flag is set, each data byte goes to the next register in turn, and the 4-bit pointer wraps around. Data aimed at pointer values that have no register is acknowledged but dropped. The register contents are presented as one flat parallel output for the analog blocks.

Top module: `ctrl_i2c_target`

## Requirements
- R1: SDA falling while SCL is high is a START. It begins address reception from any state, including in the middle of a transfer (repeated START). SDA rising while SCL is high is a STOP, which ends the transfer.
- R2: Bytes are received MSB first. For each accepted byte, `sda_oe_o` is high during the ninth SCL clock, covering the whole of its high phase. At all other times `sda_oe_o` stays low.
- R3: The address byte 0x88 (device address 7'h44 in bits 7..1, bit 0 = 0 for write) is acknowledged. Any other address, or bit 0 = 1, gets no acknowledge, and the block acknowledges and writes nothing more until the next START.
- R4: In the subaddress byte, bits 3..0 load the register pointer, bit 4 is the increment flag, and bits 7..5 have no effect.
- R5: With the increment flag at 0, every data byte of the transfer is written to the register that the subaddress named. The last byte sent is the one that remains.
- R6: With the increment flag at 1, the first data byte goes to the named register and each later byte goes to the pointer plus one. The pointer wraps from 15 to 0.
- R7: Data bytes whose pointer is 7 through 15 are acknowledged but change no register.
- R8: After reset every register holds 0xFE. Register k appears on `cfg_o[8k+7:8k]`, with k = 0 input, 1 AGC, 2 surround, 3 volume, 4 tone, 5 left balance, 6 right balance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low (acknowledge) |
| cfg_o | output | 56 | Register bank, register k in bits 8k+7..8k |

## Verification
The bench goes after the following cases.
- Pointer walk in increment mode. It runs across the unused slot 7 into the upper half, and starts a burst at 14 so the pointer wraps to register 0. An off-by-one pointer or a missing wrap shows up as a wrong or extra register change.
- Non-increment bursts. A design that advanced the pointer anyway would spread the bytes over neighbouring registers.
- Address rejection, both for a wrong address and for the read bit. A design that kept acknowledging would write registers after a rejected address.
- Repeated START in the middle of a transfer. A design that did not reset its bit counter would misframe the second address.
- Don't-care subaddress bits. A design that decoded them would write the wrong register or none.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_SKIP} rx_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_sh[STAGES-1] & ~scl_d;
  assign scl_fall_o = ~scl_sh[STAGES-1] & scl_d;
  // SDA edge while SCL is stable high
  assign start_o    = scl_sh[STAGES-1] & scl_d & sda_d & ~sda_sh[STAGES-1];
  assign stop_o     = scl_sh[STAGES-1] & scl_d & ~sda_d & sda_sh[STAGES-1];

  a_r1_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         NUM_REGS = 7,
  parameter int         SUB_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [SUB_W-1:0]  waddr_o,
  output logic [BYTE_W-1:0] wdata_o
);
  localparam logic [SUB_W-1:0] REG_LIM = SUB_W'(NUM_REGS);
  localparam logic [3:0]       ACK_BIT = 4'd8;
  localparam logic [3:0]       ACK_END = 4'd9;

  rx_state_e          st_q;
  logic [3:0]         cnt_q;
  logic [BYTE_W-1:0]  sh_q;
  logic [SUB_W-1:0]   ptr_q;
  logic               inc_q, oe_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; ptr_q <= '0;
      inc_q <= 1'b0; oe_q <= 1'b0; we_q <= 1'b0; wdata_o <= '0; waddr_o <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_i) begin
        st_q <= ST_ADDR; cnt_q <= '0; oe_q <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE; cnt_q <= '0; oe_q <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise_i && cnt_q < ACK_BIT) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_rise_i && cnt_q == ACK_BIT) begin
          cnt_q <= ACK_END;
        end else if (scl_fall_i && cnt_q == ACK_END) begin
          oe_q  <= 1'b0;
          cnt_q <= '0;
        end else if (scl_fall_i && cnt_q == ACK_BIT) begin
          unique case (st_q)
            ST_ADDR: begin
              if (sh_q[7:1] == DEV_ADDR && !sh_q[0]) begin
                oe_q <= 1'b1; st_q <= ST_SUB;
              end else begin
                st_q <= ST_SKIP;
              end
            end
            ST_SUB: begin
              oe_q  <= 1'b1;
              ptr_q <= sh_q[SUB_W-1:0];
              inc_q <= sh_q[4];
              st_q  <= ST_DATA;
            end
            ST_DATA: begin
              oe_q    <= 1'b1;
              we_q    <= (ptr_q < REG_LIM);
              waddr_o <= ptr_q;
              wdata_o <= sh_q;
              if (inc_q) ptr_q <= ptr_q + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign we_o     = we_q;

  a_r1_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == 4'd0 && st_q == ST_ADDR));
  a_r2_ack_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> cnt_q >= ACK_BIT);
  a_r3_silent_when_skipped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP || st_q == ST_IDLE) |-> !oe_q);
  a_r5_ptr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && !inc_q) |=> $stable(ptr_q));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import ctrl_pkg::*;
#(
  parameter int          NUM_REGS = 7,
  parameter int          SUB_W    = 4,
  parameter logic [7:0]  RST_VAL  = 8'hFE
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [SUB_W-1:0]             waddr_i,
  input  logic [BYTE_W-1:0]            wdata_i,
  output logic [NUM_REGS*BYTE_W-1:0]   cfg_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_o[k*BYTE_W +: BYTE_W] <= RST_VAL;
      else if (we_i && waddr_i == SUB_W'(k))
        cfg_o[k*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  a_r7_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> waddr_i < SUB_W'(NUM_REGS));
  a_r8_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/ctrl_i2c_target.sv
module ctrl_i2c_target
  import ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         NUM_REGS = 7,
  parameter int         SUB_W    = 4,
  parameter logic [7:0] RST_VAL  = 8'hFE
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*8-1:0]      cfg_o
);
  logic sda_s, scl_rise, scl_fall, start, stop, we;
  logic [SUB_W-1:0]  waddr;
  logic [BYTE_W-1:0] wdata;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_rx_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .SUB_W(SUB_W)) u_rx (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .sda_oe_o,
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .SUB_W(SUB_W), .RST_VAL(RST_VAL)) u_bank (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata), .cfg_o
  );
endmodule

// File: tb/tb_ctrl_i2c_target.sv
module tb_ctrl_i2c_target;
  localparam int N = 7;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [N*8-1:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [N];

  always #2 clk = ~clk;

  ctrl_i2c_target dut (.clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
                       .sda_oe_o(sda_oe), .cfg_o(cfg));

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < N; k++) chk(req, 64'(cfg[k*8 +: 8]), 64'(exp_r[k]));
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = ~sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    send_byte(b, a);
    chk(req, 64'(a), 64'(exp_ack));
  endtask

  task automatic t_reset;
    chk("R8 reset", 64'(sda_oe), 64'd0);
    chk_regs("R8 reset value");
  endtask

  task automatic t_single;
    bus_start;
    send_chk(8'h88, 1'b1, "R3 address ack");
    send_chk(8'hE3, 1'b1, "R4 subaddress ack");
    send_chk(8'h5A, 1'b1, "R2 data ack");
    chk("R2 oe released", 64'(sda_oe), 64'd0);
    bus_stop;
    exp_r[3] = 8'h5A;
    chk_regs("R4 dont-care bits");
  endtask

  task automatic t_nonincr;
    bus_start;
    send_chk(8'h88, 1'b1, "R3");
    send_chk(8'h01, 1'b1, "R5");
    send_chk(8'h11, 1'b1, "R5");
    send_chk(8'h22, 1'b1, "R5");
    send_chk(8'h33, 1'b1, "R5");
    bus_stop;
    exp_r[1] = 8'h33;
    chk_regs("R5 same register");
  endtask

  task automatic t_incr;
    bus_start;
    send_chk(8'h88, 1'b1, "R3");
    send_chk(8'h15, 1'b1, "R6");
    send_chk(8'hA1, 1'b1, "R6");
    send_chk(8'hA2, 1'b1, "R6");
    send_chk(8'hA3, 1'b1, "R7 ack at slot 7");
    send_chk(8'hA4, 1'b1, "R7 ack at slot 8");
    bus_stop;
    exp_r[5] = 8'hA1; exp_r[6] = 8'hA2;
    chk_regs("R6 R7 increment walk");
  endtask

  task automatic t_wrap;
    bus_start;
    send_chk(8'h88, 1'b1, "R3");
    send_chk(8'h1E, 1'b1, "R6");
    send_chk(8'hB1, 1'b1, "R7");
    send_chk(8'hB2, 1'b1, "R7");
    send_chk(8'hB3, 1'b1, "R6 wrap");
    send_chk(8'hB4, 1'b1, "R6 wrap");
    bus_stop;
    exp_r[0] = 8'hB3; exp_r[1] = 8'hB4;
    chk_regs("R6 wrap 15 to 0");
  endtask

  task automatic t_high_nonincr;
    bus_start;
    send_chk(8'h88, 1'b1, "R3");
    send_chk(8'h09, 1'b1, "R7");
    send_chk(8'h12, 1'b1, "R7 ack high slot");
    bus_stop;
    chk_regs("R7 high slot dropped");
  endtask

  task automatic t_badaddr;
    bus_start;
    send_chk(8'h8A, 1'b0, "R3 wrong address nack");
    send_chk(8'h02, 1'b0, "R3 ignored sub");
    send_chk(8'h44, 1'b0, "R3 ignored data");
    bus_stop;
    bus_start;
    send_chk(8'h89, 1'b0, "R3 read bit nack");
    send_chk(8'h02, 1'b0, "R3 ignored sub");
    send_chk(8'h44, 1'b0, "R3 ignored data");
    chk("R3 oe idle", 64'(sda_oe), 64'd0);
    bus_stop;
    chk_regs("R3 no write after reject");
  endtask

  task automatic t_rstart;
    logic a;
    bus_start;
    send_chk(8'h88, 1'b1, "R1");
    send_chk(8'h02, 1'b1, "R1");
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    send_chk(8'h88, 1'b1, "R1 repeated start address");
    send_chk(8'h04, 1'b1, "R1");
    send_byte(8'h77, a);
    chk("R1 data ack", 64'(a), 64'd1);
    bus_stop;
    exp_r[4] = 8'h77;
    chk_regs("R1 repeated start");
  endtask

  initial begin
    for (int k = 0; k < N; k++) exp_r[k] = 8'hFE;
    wq(5); rst_n = 1'b1; wq(5);
    t_reset;
    t_single;
    t_nonincr;
    t_incr;
    t_wrap;
    t_high_nonincr;
    t_badaddr;
    t_rstart;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule